// File: doc/BRIEF.md
# Symmetric-Pair FIR Tap Datapath

This block is the arithmetic core of an eight-tap FIR filter for 10-bit samples. It has two sample delay lines. The forward line is fed from one input port and the reverse line from a second one, which in a full filter would be driven by a separate reversal buffer. At every tap a pre-adder sums the forward-line sample with the reverse-line sample at the same position. That 11-bit sum is then multiplied by the tap's 10-bit coefficient, and the eight products are summed into a registered 28-bit result. With symmetric coefficients, each coefficient therefore serves two samples.

Three registered controls shape the operation. A hold control freezes the input and delay registers. Two zeroing controls each force one of the pre-adder operands to zero. Together they select symmetric, antisymmetric or plain filtering without changing the datapath. A static format input selects either fractional unsigned or fractional two's complement for samples and coefficients. The coefficients arrive as a parallel bus, with one 10-bit lane per tap.

Top module: `sfir_datapath`

## Requirements
- R1: While reset is low at a clock edge, every register clears, and `y` is zero after that edge and after the first edge with reset released.
- R2: With `hold` low and both zero controls low, `y` after edge n equals the sum over k = 0..7 of c[k]·(f[n−4−k] + r[n−4−k]). Here f[m] and r[m] are `fwd_in` and `rev_in` sampled at edge m, and c[k] is the coefficient of tap k.
- R3: `hold` is registered. When it is sampled high at edge e, the input and delay registers of both lines keep their contents at edge e+1 and at every later edge until a low value has been registered. Inputs presented meanwhile have no effect on `y`.
- R4: `zero_fwd` is registered. When it is sampled high at edge e, the forward operand of every pre-adder is zero for the sums formed at edge e+1, which reach `y` after edge e+3.
- R5: `zero_rev` behaves in the same way for the reverse operand of every pre-adder.
- R6: With `fmt_signed` = 1, samples and coefficients are two's complement. Operands are sign-extended, and `y` is a 28-bit two's complement value whose bit 0 weighs 2^-18 and whose bit 27 weighs −2^9.
- R7: With `fmt_signed` = 0, samples and coefficients are unsigned. Operands are zero-extended and `y` is an unsigned value with the same bit weights.
- R8: The pre-adder is 11 bits wide and loses no sum. With every sample and coefficient at full scale, the result is exact: 16744464 unsigned (1023,1023 / 1023), 4194304 signed (−512,−512 / −512) and −4186112 signed (511,511 / −512).
- R9: Tap k takes its coefficient from `coef_bus[10k+9:10k]`. The coefficient is sampled at the product stage, so a sample captured at edge e appears in `y` through tap k alone, after edge e+4+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_signed | input | 1 | 1 = two's complement operands, 0 = unsigned; held static while filtering |
| hold | input | 1 | 1 freezes input and delay registers (registered) |
| zero_fwd | input | 1 | 1 forces the forward pre-adder operand to zero (registered) |
| zero_rev | input | 1 | 1 forces the reverse pre-adder operand to zero (registered) |
| fwd_in | input | 10 | Sample entering the forward delay line |
| rev_in | input | 10 | Sample entering the reverse delay line |
| coef_bus | input | 80 | Eight 10-bit coefficients, tap k in bits 10k+9..10k |
| y | output | 28 | Registered filter result |

## Verification
The bench feeds a unit sample through coefficients that differ from tap to tap. A wrong pipeline depth, or a lane-swapped coefficient bus, then shows up as the wrong value arriving on the wrong cycle. Full-scale operands are driven in both formats. A pre-adder one bit too narrow, or an extension that confuses signed with unsigned, then produces a wrapped or sign-flipped result. The hold and zeroing controls are exercised while the inputs keep changing. A design that applies them a cycle early or late, or that lets samples leak past a frozen line, makes `y` drift or stay nonzero where the convolution model says otherwise.

// File: rtl/sfir_pkg.sv
// Shared types for the symmetric-pair FIR datapath.
// Assumes nothing beyond a single clock domain.
package sfir_pkg;

    // Operand interpretation for samples and coefficients.
    typedef enum logic {
        FMT_UNSIGNED = 1'b0,
        FMT_SIGNED   = 1'b1
    } sfir_fmt_e;

    // Control word captured once per clock before it acts.
    typedef struct packed {
        logic hold;
        logic zero_a;
        logic zero_b;
    } sfir_ctl_t;

endpackage

// File: rtl/sfir_ctl_reg.sv
// Control capture register: samples the hold and operand-zero controls
// on every rising edge so that they act one edge later.
// Assumes the controls are synchronous to clk.
module sfir_ctl_reg
    import sfir_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sfir_ctl_t ctl_d,
    output sfir_ctl_t ctl_q
);

    // Register the control word; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/sfir_delay_line.sv
// Sample delay line: one input register followed by TAPS stages.
// All registers advance together when adv is high and hold otherwise.
// Assumes adv is already registered by the caller.
module sfir_delay_line #(
    parameter int DW   = 10,
    parameter int TAPS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic [DW-1:0]      din,
    output logic [TAPS*DW-1:0] taps
);

    logic [DW-1:0] in_q;
    logic [DW-1:0] stage [TAPS];

    // Input register: accept a new sample only while advancing.
    always_ff @(posedge clk) begin
        if (!rst_n)   in_q <= '0;
        else if (adv) in_q <= din;
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_stage
        if (k == 0) begin : g_head
            // First stage takes the input register.
            always_ff @(posedge clk) begin
                if (!rst_n)   stage[k] <= '0;
                else if (adv) stage[k] <= in_q;
            end
        end else begin : g_body
            // Later stages take their predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n)   stage[k] <= '0;
                else if (adv) stage[k] <= stage[k-1];
            end
        end
        assign taps[k*DW +: DW] = stage[k];
    end

endmodule

// File: rtl/sfir_tap.sv
// One filter tap: a registered pre-adder of the forward and reverse
// samples, either operand forced to zero on request, followed by a
// registered multiply by the tap coefficient.
// Assumes fmt is static while data flows; the pre-add sum is kept in
// DW+1 raw bits and reinterpreted by fmt at the multiplier.
module sfir_tap
    import sfir_pkg::*;
#(
    parameter int DW  = 10,
    parameter int CW  = 10,
    localparam int PW  = DW + 1,
    localparam int PRW = DW + CW + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  sfir_fmt_e             fmt,
    input  logic                  zero_a,
    input  logic                  zero_b,
    input  logic [DW-1:0]         fwd,
    input  logic [DW-1:0]         rev,
    input  logic [CW-1:0]         coef,
    output logic [PW-1:0]         psum_q,
    output logic signed [PRW-1:0] prod_q
);

    logic [PW-1:0]        a_ext, b_ext, psum_d;
    logic signed [PW:0]   p_ext;
    logic signed [CW:0]   c_ext;
    logic signed [PRW-1:0] prod_d;

    // Extend both operands by format and apply the zeroing controls.
    always_comb begin
        a_ext  = (fmt == FMT_SIGNED) ? {fwd[DW-1], fwd} : {1'b0, fwd};
        b_ext  = (fmt == FMT_SIGNED) ? {rev[DW-1], rev} : {1'b0, rev};
        if (zero_a) a_ext = '0;
        if (zero_b) b_ext = '0;
        psum_d = a_ext + b_ext;
    end

    // Reinterpret the raw sum and coefficient for a signed multiply.
    always_comb begin
        p_ext  = (fmt == FMT_SIGNED) ? {psum_q[PW-1], psum_q} : {1'b0, psum_q};
        c_ext  = (fmt == FMT_SIGNED) ? {coef[CW-1], coef} : {1'b0, coef};
        prod_d = p_ext * c_ext;
    end

    // Pre-add and product pipeline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psum_q <= '0;
            prod_q <= '0;
        end else begin
            psum_q <= psum_d;
            prod_q <= prod_d;
        end
    end

endmodule

// File: rtl/sfir_sum.sv
// Output summer: sign-extends every tap product to the output width,
// adds them and registers the total.
// Assumes OW leaves room for TAPS products without overflow.
module sfir_sum #(
    parameter int TAPS = 8,
    parameter int PRW  = 23,
    parameter int OW   = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TAPS*PRW-1:0] prods,
    output logic [OW-1:0]       y
);

    logic [OW-1:0]  acc;
    logic [PRW-1:0] p;

    // Accumulate the sign-extended products.
    always_comb begin
        acc = '0;
        p   = '0;
        for (int k = 0; k < TAPS; k++) begin
            p   = prods[k*PRW +: PRW];
            acc = acc + {{(OW-PRW){p[PRW-1]}}, p};
        end
    end

    // Register the filter result.
    always_ff @(posedge clk) begin
        if (!rst_n) y <= '0;
        else        y <= acc;
    end

endmodule

// File: rtl/sfir_datapath.sv
// Symmetric-pair FIR datapath top: registered controls, forward and
// reverse delay lines, TAPS pre-add/multiply taps and the output summer.
// Latency from a captured sample to y through tap k is 4+k edges.
// Assumes fmt_signed and coef_bus are quasi-static while filtering.
module sfir_datapath
    import sfir_pkg::*;
#(
    parameter int DW   = 10,
    parameter int CW   = 10,
    parameter int TAPS = 8,
    parameter int OW   = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fmt_signed,
    input  logic               hold,
    input  logic               zero_fwd,
    input  logic               zero_rev,
    input  logic [DW-1:0]      fwd_in,
    input  logic [DW-1:0]      rev_in,
    input  logic [TAPS*CW-1:0] coef_bus,
    output logic [OW-1:0]      y
);

    localparam int PW  = DW + 1;
    localparam int PRW = DW + CW + 3;

    sfir_ctl_t ctl_d, ctl_q;
    sfir_fmt_e fmt;
    logic      hold_q, zf_q, zr_q, adv;
    logic [TAPS*DW-1:0]  fwd_taps, rev_taps;
    logic [TAPS*PW-1:0]  psum_all;
    logic [TAPS*PRW-1:0] prod_all;

    assign ctl_d  = '{hold: hold, zero_a: zero_fwd, zero_b: zero_rev};
    assign hold_q = ctl_q.hold;
    assign zf_q   = ctl_q.zero_a;
    assign zr_q   = ctl_q.zero_b;
    assign adv    = !hold_q;
    assign fmt    = sfir_fmt_e'(fmt_signed);

    sfir_ctl_reg i_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl_d (ctl_d),
        .ctl_q (ctl_q)
    );

    sfir_delay_line #(.DW(DW), .TAPS(TAPS)) i_fwd_line (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .din   (fwd_in),
        .taps  (fwd_taps)
    );

    sfir_delay_line #(.DW(DW), .TAPS(TAPS)) i_rev_line (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .din   (rev_in),
        .taps  (rev_taps)
    );

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic signed [PRW-1:0] prod_k;
        sfir_tap #(.DW(DW), .CW(CW)) i_tap (
            .clk    (clk),
            .rst_n  (rst_n),
            .fmt    (fmt),
            .zero_a (zf_q),
            .zero_b (zr_q),
            .fwd    (fwd_taps[k*DW +: DW]),
            .rev    (rev_taps[k*DW +: DW]),
            .coef   (coef_bus[k*CW +: CW]),
            .psum_q (psum_all[k*PW +: PW]),
            .prod_q (prod_k)
        );
        assign prod_all[k*PRW +: PRW] = prod_k;
    end

    sfir_sum #(.TAPS(TAPS), .PRW(PRW), .OW(OW)) i_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .prods (prod_all),
        .y     (y)
    );

endmodule

// File: rtl/sfir_checker.sv
// Assertion checker for sfir_datapath, attached by bind below.
// Observes the output, the registered controls, the delay lines and
// the first tap's pipeline registers.
module sfir_checker #(
    parameter int DW   = 10,
    parameter int TAPS = 8,
    parameter int OW   = 28,
    parameter int PRW  = 23
) (
    input logic               clk,
    input logic               rst_n,
    input logic [OW-1:0]      y,
    input logic               hold_q,
    input logic               zf_q,
    input logic               zr_q,
    input logic [TAPS*DW-1:0] fwd_taps,
    input logic [TAPS*DW-1:0] rev_taps,
    input logic [DW:0]        psum0,
    input logic [PRW-1:0]     prod0
);

    // R1: the output is clear on the first edge after reset is released.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (y == '0));

    // R3: a registered hold freezes both delay lines.
    assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> ($stable(fwd_taps) && $stable(rev_taps)));

    // R4 and R5: both operands zeroed gives a zero result two stages later.
    assert_both_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(zf_q && zr_q, 3) |-> (y == '0));

    // R9: a zero pre-add sum yields a zero product on the next edge.
    assert_prod_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (psum0 == '0) |=> (prod0 == '0));

endmodule

bind sfir_datapath sfir_checker #(
    .DW(DW), .TAPS(TAPS), .OW(OW), .PRW(PRW)
) u_sfir_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .y        (y),
    .hold_q   (hold_q),
    .zf_q     (zf_q),
    .zr_q     (zr_q),
    .fwd_taps (fwd_taps),
    .rev_taps (rev_taps),
    .psum0    (psum_all[DW:0]),
    .prod0    (prod_all[PRW-1:0])
);

// File: tb/test_sfir_datapath.sv
// Self-checking bench for sfir_datapath: a behavioural convolution
// model with the pipeline latency, random stimulus and directed cases.
module test_sfir_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_signed = 1'b0;
    logic        hold = 1'b0;
    logic        zero_fwd = 1'b0;
    logic        zero_rev = 1'b0;
    logic [9:0]  fwd_in = '0;
    logic [9:0]  rev_in = '0;
    logic [79:0] coef_bus;
    logic [27:0] y;

    logic [9:0] cf [8];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    chk_en = 1'b0;
    string cur_req = "R2";

    always #4 clk = ~clk;

    always_comb
        for (int k = 0; k < 8; k++) coef_bus[k*10 +: 10] = cf[k];

    sfir_datapath i_sfir_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_signed (fmt_signed),
        .hold       (hold),
        .zero_fwd   (zero_fwd),
        .zero_rev   (zero_rev),
        .fwd_in     (fwd_in),
        .rev_in     (rev_in),
        .coef_bus   (coef_bus),
        .y          (y)
    );

    // ---------------- behavioural model ----------------
    logic [9:0] mf [8];
    logic [9:0] mr [8];
    logic [9:0] mif, mir;
    bit mh, mzf, mzr;
    int e1, e2, e3;

    function automatic int ext10(logic [9:0] v, bit s);
        return s ? int'(signed'(v)) : int'(v);
    endfunction

    function automatic int conv_now();
        int acc = 0;
        for (int k = 0; k < 8; k++) begin
            int a = mzf ? 0 : ext10(mf[k], fmt_signed);
            int b = mzr ? 0 : ext10(mr[k], fmt_signed);
            acc += ext10(cf[k], fmt_signed) * (a + b);
        end
        return acc;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mh <= 0; mzf <= 0; mzr <= 0; mif <= '0; mir <= '0;
            e1 <= 0; e2 <= 0; e3 <= 0;
            for (int k = 0; k < 8; k++) begin mf[k] <= '0; mr[k] <= '0; end
        end else begin
            mh <= hold; mzf <= zero_fwd; mzr <= zero_rev;
            if (!mh) begin
                mif <= fwd_in; mir <= rev_in;
                mf[0] <= mif; mr[0] <= mir;
                for (int k = 1; k < 8; k++) begin mf[k] <= mf[k-1]; mr[k] <= mr[k-1]; end
            end
            e1 <= conv_now(); e2 <= e1; e3 <= e2;
        end
    end

    task automatic check(string req, logic [27:0] act, logic [27:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: y=%0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model.
    always @(negedge clk)
        if (chk_en && rst_n) check(cur_req, y, 28'(e3));

    task automatic set_cfg(bit s, bit rnd, logic [9:0] cval);
        @(negedge clk);
        chk_en = 0;
        fmt_signed = s;
        for (int k = 0; k < 8; k++) cf[k] = rnd ? 10'($urandom) : cval;
        repeat (4) @(negedge clk);
        chk_en = 1;
    endtask

    task automatic steady(logic [9:0] f, logic [9:0] r, int n);
        fwd_in = f; rev_in = r;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1600000;
        n_checks++; n_errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [27:0] ref_y;
        void'($urandom(32'h5F1A_0C3D));
        for (int k = 0; k < 8; k++) cf[k] = 10'd1;
        // R1: reset clears output even with active inputs.
        fwd_in = 10'h155; rev_in = 10'h2AA;
        repeat (5) @(negedge clk);
        check("R1", y, 28'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", y, 28'd0);
        chk_en = 1;

        // R2 R9: unit sample through distinct per-tap coefficients.
        cur_req = "R9";
        @(negedge clk); chk_en = 0; fmt_signed = 0;
        for (int k = 0; k < 8; k++) cf[k] = 10'(k + 1);
        steady(10'd0, 10'd0, 14);
        chk_en = 1;
        fwd_in = 10'd1;
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            fwd_in = 10'd0;
            if (i < 4) check("R2", y, 28'd0);
            else if (i < 12) check("R9", y, 28'(i - 3));
        end

        // R3: hold freezes the lines while inputs change.
        cur_req = "R3";
        set_cfg(0, 1, 10'd0);
        for (int i = 0; i < 12; i++) begin
            fwd_in = 10'($urandom); rev_in = 10'($urandom);
            @(negedge clk);
        end
        hold = 1;
        repeat (6) @(negedge clk);
        ref_y = y;
        for (int i = 0; i < 6; i++) begin
            fwd_in = 10'($urandom); rev_in = 10'($urandom);
            @(negedge clk);
            check("R3", y, ref_y);
        end
        hold = 0;
        repeat (12) @(negedge clk);

        // R4: forward operand zeroed, reverse line empty.
        cur_req = "R4";
        rev_in = 10'd0;
        for (int i = 0; i < 12; i++) begin fwd_in = 10'($urandom); @(negedge clk); end
        zero_fwd = 1;
        for (int i = 0; i < 6; i++) begin
            fwd_in = 10'($urandom);
            @(negedge clk);
            if (i >= 3) check("R4", y, 28'd0);
        end
        zero_fwd = 0;

        // R5: reverse operand zeroed, forward line empty.
        cur_req = "R5";
        fwd_in = 10'd0;
        for (int i = 0; i < 12; i++) begin rev_in = 10'($urandom); @(negedge clk); end
        zero_rev = 1;
        for (int i = 0; i < 6; i++) begin
            rev_in = 10'($urandom);
            @(negedge clk);
            if (i >= 3) check("R5", y, 28'd0);
        end
        zero_rev = 0;

        // R8 R7: unsigned full scale.
        cur_req = "R8";
        set_cfg(0, 0, 10'h3FF);
        steady(10'h3FF, 10'h3FF, 14);
        check("R8", y, 28'd16744464);
        // R8 R6: signed most negative.
        set_cfg(1, 0, 10'h200);
        steady(10'h200, 10'h200, 14);
        check("R8", y, 28'd4194304);
        // R6: signed most positive data, negative coefficient.
        steady(10'h1FF, 10'h1FF, 14);
        check("R6", y, 28'(-4186112));

        // R6 R7: random stimulus in each format, with hold and zeroing.
        for (int m = 0; m < 2; m++) begin
            cur_req = (m == 0) ? "R6" : "R7";
            set_cfg(m == 0, 1, 10'd0);
            for (int i = 0; i < 1500; i++) begin
                fwd_in   = 10'($urandom);
                rev_in   = 10'($urandom);
                hold     = ($urandom % 10) == 0;
                zero_fwd = ($urandom % 10) == 0;
                zero_rev = ($urandom % 10) == 0;
                @(negedge clk);
            end
            hold = 0; zero_fwd = 0; zero_rev = 0;
        end
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule